// File: doc/BRIEF.md
# Buffer Pool Depletion Hysteresis Monitor

This block keeps the free-buffer count of one buffer pool and derives two depletion states from that single count. One state serves software: when it becomes depleted, a one-cycle replenish notification is raised. The other state serves hardware consumers: while it is depleted, a pushback output is held high, for example so that a MAC can request pause frames.

Each state has its own entry threshold and its own exit threshold, and the gap between them forms the hysteresis band. Acquire strobes take one buffer from the count and release strobes return one. An acquire against an empty pool is reported as an underflow and leaves the count at zero. A state whose two thresholds are both zero is disabled and never asserts its flag.

Top module: `pool_deplete_mon`

## Requirements
- R1: After reset the count equals the parameter INIT_COUNT, and both depletion flags, all four notification pulses and the underflow output are 0.
- R2: A release alone raises the count by one and an acquire alone lowers it by one, with the new value visible on count_o one cycle after the strobe. A release alone at the all-ones count leaves the count unchanged.
- R3: An acquire and a release in the same cycle leave the count, the flags and the pulses unchanged.
- R4: An acquire alone while the count is zero leaves the count at zero and pulses underflow_o high for exactly one cycle. No flag changes.
- R5: A count update is a cycle in which the count changes. On a count update, an enabled state that is not depleted becomes depleted when the new count is strictly below its entry threshold.
- R6: On a count update, a depleted state is cleared only when the new count is strictly above its exit threshold. Counts between the thresholds keep the current state.
- R7: The software state uses sw_enter_th_i and sw_exit_th_i only, and the hardware state uses hw_enter_th_i and hw_exit_th_i only. Neither state affects the other.
- R8: Each flag transition produces a one-cycle pulse in the same cycle as the flag change: sw_replenish_o on software entry, sw_exit_o on software exit, hw_enter_o on hardware entry and hw_exit_o on hardware exit. No pulse occurs without a transition.
- R9: pushback_o is the hardware depletion flag.
- R10: A state whose entry and exit thresholds are both zero is disabled. At the next count update its flag is cleared, with an exit pulse if it was set, and the flag then stays 0.
- R11: A change to a threshold input has no effect until the next count update, and it does not change a flag by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_i | input | 1 | Acquire strobe; takes one buffer |
| rel_i | input | 1 | Release strobe; returns one buffer |
| sw_enter_th_i | input | CNT_W | Software entry threshold |
| sw_exit_th_i | input | CNT_W | Software exit threshold |
| hw_enter_th_i | input | CNT_W | Hardware entry threshold |
| hw_exit_th_i | input | CNT_W | Hardware exit threshold |
| count_o | output | CNT_W | Current free-buffer count |
| sw_depleted_o | output | 1 | Software depletion flag |
| pushback_o | output | 1 | Hardware depletion flag, used as pushback |
| sw_replenish_o | output | 1 | Pulse on entry into software depletion |
| sw_exit_o | output | 1 | Pulse on exit from software depletion |
| hw_enter_o | output | 1 | Pulse on entry into hardware depletion |
| hw_exit_o | output | 1 | Pulse on exit from hardware depletion |
| underflow_o | output | 1 | Pulse when an acquire meets an empty pool |

## Verification
Every output is registered once after the strobe that causes it. The count, both flags, the four transition pulses and the underflow pulse all appear on the first rising edge after the strobe is sampled, and the pulses fall again on the edge after that. The bench drives strobes and thresholds on falling edges and compares all outputs at the next falling edge against a model it updates once per step. This also catches a pulse that lasts a second cycle, because the following step then expects 0. Threshold changes are checked with idle steps placed between the write and the next count update.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int NUM_STATES = 2;

  typedef enum logic [0:0] {
    ST_SW = 1'b0,
    ST_HW = 1'b1
  } state_idx_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'b00,
    EV_DEC   = 2'b01,
    EV_INC   = 2'b10,
    EV_UNDER = 2'b11
  } count_ev_e;
endpackage

// File: rtl/pdm_counter.sv
module pdm_counter #(
  parameter int CNT_W      = 16,
  parameter int INIT_COUNT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_i,
  input  logic             rel_i,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_d,
  output logic             update,
  output logic             underflow_q
);
  import pdm_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO  = '0;
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(INIT_COUNT);

  count_ev_e ev;
  logic      underflow_d;
  logic      cnt_en;

  // classify the strobe pair for this cycle
  always_comb begin
    ev = EV_NONE;
    if (acq_i && !rel_i) begin
      if (count_q == CNT_ZERO) ev = EV_UNDER;
      else                     ev = EV_DEC;
    end else if (rel_i && !acq_i) begin
      if (count_q != CNT_MAX)  ev = EV_INC;
    end
  end

  always_comb begin
    count_d     = count_q;
    update      = 1'b0;
    underflow_d = 1'b0;
    case (ev)
      EV_DEC: begin
        count_d = count_q - CNT_ONE;
        update  = 1'b1;
      end
      EV_INC: begin
        count_d = count_q + CNT_ONE;
        update  = 1'b1;
      end
      EV_UNDER: underflow_d = 1'b1;
      default: ;
    endcase
  end

  assign cnt_en = update;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_RESET;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underflow_q <= 1'b0;
    end else begin
      underflow_q <= underflow_d;
    end
  end
endmodule

// File: rtl/pdm_hyst.sv
module pdm_hyst #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [CNT_W-1:0] count_d,
  input  logic [CNT_W-1:0] enter_th,
  input  logic [CNT_W-1:0] exit_th,
  output logic             flag_q,
  output logic             enter_pulse_q,
  output logic             exit_pulse_q
);
  localparam logic [CNT_W-1:0] TH_ZERO = '0;

  logic disabled;
  logic below_enter;
  logic above_exit;
  logic flag_d;
  logic enter_d;
  logic exit_d;

  assign disabled    = (enter_th == TH_ZERO) && (exit_th == TH_ZERO);
  assign below_enter = count_d < enter_th;
  assign above_exit  = count_d > exit_th;

  always_comb begin
    flag_d = flag_q;
    if (update) begin
      if (disabled)                  flag_d = 1'b0;
      else if (!flag_q && below_enter) flag_d = 1'b1;
      else if (flag_q && above_exit)   flag_d = 1'b0;
    end
  end

  assign enter_d = flag_d & ~flag_q;
  assign exit_d  = flag_q & ~flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (update) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enter_pulse_q <= 1'b0;
      exit_pulse_q  <= 1'b0;
    end else begin
      enter_pulse_q <= enter_d;
      exit_pulse_q  <= exit_d;
    end
  end
endmodule

// File: rtl/pool_deplete_mon.sv
module pool_deplete_mon #(
  parameter int CNT_W      = 16,
  parameter int INIT_COUNT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_i,
  input  logic             rel_i,
  input  logic [CNT_W-1:0] sw_enter_th_i,
  input  logic [CNT_W-1:0] sw_exit_th_i,
  input  logic [CNT_W-1:0] hw_enter_th_i,
  input  logic [CNT_W-1:0] hw_exit_th_i,
  output logic [CNT_W-1:0] count_o,
  output logic             sw_depleted_o,
  output logic             pushback_o,
  output logic             sw_replenish_o,
  output logic             sw_exit_o,
  output logic             hw_enter_o,
  output logic             hw_exit_o,
  output logic             underflow_o
);
  import pdm_pkg::*;

  logic [CNT_W-1:0] count_d;
  logic             update;

  logic [CNT_W-1:0] enter_th [NUM_STATES];
  logic [CNT_W-1:0] exit_th  [NUM_STATES];
  logic [NUM_STATES-1:0] flag;
  logic [NUM_STATES-1:0] enter_p;
  logic [NUM_STATES-1:0] exit_p;

  assign enter_th[ST_SW] = sw_enter_th_i;
  assign exit_th[ST_SW]  = sw_exit_th_i;
  assign enter_th[ST_HW] = hw_enter_th_i;
  assign exit_th[ST_HW]  = hw_exit_th_i;

  pdm_counter #(
    .CNT_W      (CNT_W),
    .INIT_COUNT (INIT_COUNT)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_i       (acq_i),
    .rel_i       (rel_i),
    .count_q     (count_o),
    .count_d     (count_d),
    .update      (update),
    .underflow_q (underflow_o)
  );

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_state
    pdm_hyst #(
      .CNT_W (CNT_W)
    ) u_hyst (
      .clk           (clk),
      .rst_n         (rst_n),
      .update        (update),
      .count_d       (count_d),
      .enter_th      (enter_th[g]),
      .exit_th       (exit_th[g]),
      .flag_q        (flag[g]),
      .enter_pulse_q (enter_p[g]),
      .exit_pulse_q  (exit_p[g])
    );
  end

  assign sw_depleted_o  = flag[ST_SW];
  assign pushback_o     = flag[ST_HW];
  assign sw_replenish_o = enter_p[ST_SW];
  assign sw_exit_o      = exit_p[ST_SW];
  assign hw_enter_o     = enter_p[ST_HW];
  assign hw_exit_o      = exit_p[ST_HW];
endmodule

// File: rtl/pool_deplete_mon_chk.sv
module pool_deplete_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_i,
  input logic             rel_i,
  input logic [CNT_W-1:0] sw_enter_th_i,
  input logic [CNT_W-1:0] sw_exit_th_i,
  input logic [CNT_W-1:0] count_o,
  input logic             sw_depleted_o,
  input logic             pushback_o,
  input logic             sw_replenish_o,
  input logic             sw_exit_o,
  input logic             hw_enter_o,
  input logic             hw_exit_o,
  input logic             underflow_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // R3: simultaneous strobes hold the count and the flags
  p_both_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_i && rel_i) |=> ($stable(count_o) && $stable(sw_depleted_o) && $stable(pushback_o)));

  // R2: lone acquire on a non-empty pool lowers the count by one
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_i && !rel_i && count_o != ZERO) |=> (count_o == $past(count_o) - ONE));

  // R4: acquire at zero reports underflow and keeps zero
  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_i && !rel_i && count_o == ZERO) |=> (underflow_o && count_o == ZERO));

  // R8: software entry pulse coincides with a rising software flag
  p_sw_enter_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_replenish_o |-> $rose(sw_depleted_o));

  // R8: hardware exit pulse coincides with a falling pushback
  p_hw_exit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_exit_o |-> $fell(pushback_o));

  // R8: pulses last one cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_replenish_o || sw_exit_o || hw_enter_o || hw_exit_o) |=>
      !($past(sw_replenish_o) && sw_replenish_o) && !($past(hw_enter_o) && hw_enter_o));

  // R11: with no strobe the flags do not move, whatever the thresholds do
  p_idle_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_i && !rel_i) |=> ($stable(sw_depleted_o) && $stable(pushback_o)));

  // R10: disabled software state is clear after a count update
  p_sw_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((acq_i ^ rel_i) && !underflow_o && sw_enter_th_i == ZERO && sw_exit_th_i == ZERO
      && count_o != ZERO && count_o != {CNT_W{1'b1}}) |=> !sw_depleted_o);
endmodule

bind pool_deplete_mon pool_deplete_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acq_i          (acq_i),
  .rel_i          (rel_i),
  .sw_enter_th_i  (sw_enter_th_i),
  .sw_exit_th_i   (sw_exit_th_i),
  .count_o        (count_o),
  .sw_depleted_o  (sw_depleted_o),
  .pushback_o     (pushback_o),
  .sw_replenish_o (sw_replenish_o),
  .sw_exit_o      (sw_exit_o),
  .hw_enter_o     (hw_enter_o),
  .hw_exit_o      (hw_exit_o),
  .underflow_o    (underflow_o)
);

// File: tb/pool_deplete_mon_tb.sv
module pool_deplete_mon_tb;
  localparam int CNT_W = 6;
  localparam int INIT  = 40;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq = 1'b0, rel = 1'b0;
  logic [CNT_W-1:0] swe = '0, swx = '0, hwe = '0, hwx = '0;
  logic [CNT_W-1:0] count;
  logic sw_dep, pb, sw_rep, sw_ex, hw_en, hw_ex, uf;

  int checks = 0;
  int failures = 0;
  int m_cnt;
  logic m_sw, m_hw;

  always #2.5 clk = ~clk;

  pool_deplete_mon #(.CNT_W(CNT_W), .INIT_COUNT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq_i(acq), .rel_i(rel),
    .sw_enter_th_i(swe), .sw_exit_th_i(swx),
    .hw_enter_th_i(hwe), .hw_exit_th_i(hwx),
    .count_o(count), .sw_depleted_o(sw_dep), .pushback_o(pb),
    .sw_replenish_o(sw_rep), .sw_exit_o(sw_ex),
    .hw_enter_o(hw_en), .hw_exit_o(hw_ex), .underflow_o(uf)
  );

  function automatic logic next_flag(logic f, int c, int en, int ex);
    if (en == 0 && ex == 0) return 1'b0;
    if (!f && c < en) return 1'b1;
    if (f && c > ex) return 1'b0;
    return f;
  endfunction

  task automatic compare(string tag, int e_cnt, logic e_sw, logic e_hw,
                         logic e_srep, logic e_sex, logic e_hen, logic e_hex, logic e_uf);
    logic [9:0] act, exp;
    act = {sw_dep, pb, sw_rep, sw_ex, hw_en, hw_ex, uf, 3'b000};
    exp = {e_sw, e_hw, e_srep, e_sex, e_hen, e_hex, e_uf, 3'b000};
    checks++;
    if (int'(count) != e_cnt || act != exp) begin
      failures++;
      $display("FAIL %s count=%0d exp=%0d flags=%b exp=%b", tag, count, e_cnt, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs compared at the next falling edge
  task automatic step(string tag, logic a, logic r);
    logic e_uf, upd, n_sw, n_hw;
    acq = a; rel = r;
    @(negedge clk);
    acq = 1'b0; rel = 1'b0;
    e_uf = a && !r && m_cnt == 0;
    upd = 1'b0;
    if (a && !r && m_cnt > 0) begin m_cnt--; upd = 1'b1; end
    if (r && !a && m_cnt < MAXC) begin m_cnt++; upd = 1'b1; end
    n_sw = upd ? next_flag(m_sw, m_cnt, int'(swe), int'(swx)) : m_sw;
    n_hw = upd ? next_flag(m_hw, m_cnt, int'(hwe), int'(hwx)) : m_hw;
    compare(tag, m_cnt, n_sw, n_hw, n_sw & ~m_sw, m_sw & ~n_sw,
            n_hw & ~m_hw, m_hw & ~n_hw, e_uf);
    m_sw = n_sw; m_hw = n_hw;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_cnt = INIT; m_sw = 1'b0; m_hw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    compare("R1", INIT, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", INIT, 0, 0, 0, 0, 0, 0, 0);

    // R7 separate pairs: software 8/32, hardware 4/16
    swe = 6'd8; swx = 6'd32; hwe = 6'd4; hwx = 6'd16;
    // R5 R9 walk down to empty, both states enter at their own points
    for (int i = 0; i < INIT; i++) step(i < 35 ? "R5" : "R9", 1'b1, 1'b0);
    // R4 acquire against an empty pool, twice
    step("R4", 1'b1, 1'b0);
    step("R4", 1'b1, 1'b0);
    // R8 idle step: pulses gone
    step("R8", 1'b0, 1'b0);
    // R6 walk up to full; exits only above exit thresholds
    for (int i = 0; i < MAXC; i++) step("R6", 1'b0, 1'b1);
    // R2 release at full saturates
    step("R2", 1'b0, 1'b1);
    // R3 simultaneous strobes
    step("R3", 1'b1, 1'b1);
    // R10 disable software state, walk down to 2
    swe = '0; swx = '0;
    for (int i = 0; i < MAXC - 2; i++) step("R10", 1'b1, 1'b0);
    // R3 at a depleted point
    step("R3", 1'b1, 1'b1);
    // R11 hardware depleted at 2; lower exit to 1: idle keeps state
    hwx = 6'd1;
    step("R11", 1'b0, 1'b0);
    step("R11", 1'b0, 1'b0);
    step("R11", 1'b0, 1'b1);   // 3 > 1 -> exit now
    // R11 re-enable software at count 3: no change until an update
    swe = 6'd8; swx = 6'd32;
    step("R11", 1'b0, 1'b0);
    step("R7", 1'b1, 1'b0);    // 2 < 8 software enters, hardware 2 < 4 enters
    // R10 disable while depleted: next update clears with exit pulse
    swe = '0; swx = '0;
    step("R10", 1'b0, 1'b0);
    step("R10", 1'b0, 1'b1);
    step("R8", 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule